// File: doc/BRIEF.md
# Multi-Mode Self-Test Observation Register

This block is a bank of flip-flops that can act in four ways, chosen by a two-bit mode code. In functional operation it captures a parallel word. For scan access it becomes a serial shift chain, which lets a tester load or unload its contents one bit per clock. In self-test operation it becomes a linear feedback shift register. With its parallel inputs held at zero it produces a pseudo-random pattern sequence. With responses on its parallel inputs it folds each response into a running signature. A fourth code clears it synchronously.

Typically the block sits between two clouds of logic under test. One instance can drive patterns into a cloud while a second instance compacts that cloud's responses. The test controller seeds each instance through scan or a parallel load, runs it in self-test mode, and then shifts the signature out for comparison. The width and the feedback tap selection are parameters. The default is a 3-bit register whose taps are bits 2 and 0.

Top module: `logic_block_observer`

## Requirements
- R1: With mode code 2'b11 (load), the register takes `par_in` at the clock edge, and `par_out` shows it from that edge on.
- R2: With mode code 2'b00 (shift), bit 0 takes `scan_in` and each bit i>0 takes the old bit i-1 at the clock edge.
- R3: `scan_out` equals `par_out[WIDTH-1]` in every mode and every cycle, and `par_out` always shows the register contents.
- R4: With mode code 2'b10 (clear), every bit is zero after the clock edge.
- R5: With mode code 2'b01 (self-test) and `par_in` zero, bit i>0 takes the old bit i-1 and bit 0 takes the XOR of the old bits selected by `TAP_MASK`. At the default (WIDTH 3, mask 3'b101), seed 3'b111 steps through 110, 101, 010, 100, 001, 011 and returns to 111 after 7 edges.
- R6: With mode code 2'b01 and a nonzero `par_in`, each bit's next value is its R5 value XORed with the matching `par_in` bit. At the default, from seed 3'b111 the inputs 011, 101, 000, 110, 001, 111 leave the signature 3'b010.
- R7: In mode 2'b01 with `par_in` zero, an all-zero register stays all-zero.
- R8: Shifting a WIDTH-bit word in most significant bit first over WIDTH edges leaves that word in the register. A further WIDTH shifts present it on `scan_out`, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| mode | input | 2 | 00 shift, 01 self-test, 10 clear, 11 load |
| par_in | input | WIDTH | Parallel data / response inputs |
| scan_in | input | 1 | Serial input into bit 0 |
| par_out | output | WIDTH | Current register contents |
| scan_out | output | 1 | Last stage of the chain |

## Verification
The hardest state to reach is a particular signature after a run of compaction steps. It depends on the seed, on every response vector, and on the order in which they arrive. From the ports alone, the feedback cannot be told apart from the data folding. The stimulus first seeds a known word through a parallel load. It then steps the pure pattern cycle against a fixed table, so the feedback alone is pinned down. Only after that does it feed a fixed response sequence whose final signature was worked out by hand. The locked all-zero state is entered on purpose through the clear code to show that the generator cannot leave it.

// File: rtl/obs_pkg.sv
package obs_pkg;

  typedef enum logic [1:0] {
    OBS_SHIFT = 2'b00,
    OBS_SIGN  = 2'b01,
    OBS_CLEAR = 2'b10,
    OBS_LOAD  = 2'b11
  } obs_mode_e;

  typedef struct packed {
    logic shift;
    logic sign;
    logic clear;
    logic load;
  } obs_sel_t;

  localparam int OBS_MAXW = 64;

  // Parity of the state bits picked out by a tap mask (zero-extended).
  function automatic logic fold_taps(input logic [OBS_MAXW-1:0] state,
                                     input logic [OBS_MAXW-1:0] mask);
    return ^(state & mask);
  endfunction

  // Next value of one stage given its selected source and its data bit.
  function automatic logic stage_next(input obs_sel_t sel,
                                      input logic scan_src,
                                      input logic sig_src,
                                      input logic din,
                                      input logic cur);
    logic nxt;
    nxt = cur;
    if (sel.clear)      nxt = 1'b0;
    else if (sel.load)  nxt = din;
    else if (sel.shift) nxt = scan_src;
    else if (sel.sign)  nxt = sig_src ^ din;
    return nxt;
  endfunction

endpackage

// File: rtl/obs_mode_decode.sv
module obs_mode_decode
  import obs_pkg::*;
(
  input  logic [1:0] mode,
  output obs_sel_t   sel
);
  obs_mode_e m;
  assign m = obs_mode_e'(mode);

  always_comb begin
    sel = '0;
    unique case (m)
      OBS_SHIFT: sel.shift = 1'b1;
      OBS_SIGN:  sel.sign  = 1'b1;
      OBS_CLEAR: sel.clear = 1'b1;
      OBS_LOAD:  sel.load  = 1'b1;
      default:   sel = '0;
    endcase
  end
endmodule

// File: rtl/obs_feedback.sv
module obs_feedback
  import obs_pkg::*;
#(
  parameter int               WIDTH    = 3,
  parameter logic [WIDTH-1:0] TAP_MASK = 'b101
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb_bit
);
  assign fb_bit = fold_taps(OBS_MAXW'(state), OBS_MAXW'(TAP_MASK));
endmodule

// File: rtl/obs_stage.sv
module obs_stage
  import obs_pkg::*;
(
  input  logic     clk,
  input  obs_sel_t sel,
  input  logic     scan_src,
  input  logic     sig_src,
  input  logic     din,
  output logic     q
);
  logic q_next;
  assign q_next = stage_next(sel, scan_src, sig_src, din, q);

  always_ff @(posedge clk) begin
    q <= q_next;
  end
endmodule

// File: rtl/logic_block_observer.sv
module logic_block_observer
  import obs_pkg::*;
#(
  parameter int               WIDTH    = 3,
  parameter logic [WIDTH-1:0] TAP_MASK = 'b101
) (
  input  logic             clk,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] par_out,
  output logic             scan_out
);
  localparam int LAST = WIDTH - 1;

  obs_sel_t         sel;
  logic             fb_bit;
  logic [WIDTH-1:0] state;
  logic [WIDTH-1:0] scan_link;
  logic [WIDTH-1:0] sig_link;

  obs_mode_decode u_dec (
    .mode (mode),
    .sel  (sel)
  );

  obs_feedback #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_fb (
    .state  (state),
    .fb_bit (fb_bit)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign scan_link[i] = scan_in;
      assign sig_link[i]  = fb_bit;
    end else begin : g_body
      assign scan_link[i] = state[i-1];
      assign sig_link[i]  = state[i-1];
    end

    obs_stage u_stage (
      .clk      (clk),
      .sel      (sel),
      .scan_src (scan_link[i]),
      .sig_src  (sig_link[i]),
      .din      (par_in[i]),
      .q        (state[i])
    );
  end

  assign par_out  = state;
  assign scan_out = state[LAST];
endmodule

// File: rtl/logic_block_observer_chk.sv
module logic_block_observer_chk #(
  parameter int               WIDTH    = 3,
  parameter logic [WIDTH-1:0] TAP_MASK = 'b101
) (
  input logic             clk,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] par_in,
  input logic             scan_in,
  input logic [WIDTH-1:0] par_out,
  input logic             scan_out,
  input logic             fb_bit
);
  // Checks start once a clear has put the register in a known state.
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (mode == 2'b10) armed <= 1'b1;
  end

  p_load_r1: assert property (@(posedge clk) disable iff (!armed)
    mode == 2'b11 |=> par_out == $past(par_in));

  p_shift_r2: assert property (@(posedge clk) disable iff (!armed)
    mode == 2'b00 |=> par_out == {$past(par_out[WIDTH-2:0]), $past(scan_in)});

  p_tail_r3: assert property (@(posedge clk) disable iff (!armed)
    scan_out == par_out[WIDTH-1]);

  p_clear_r4: assert property (@(posedge clk) disable iff (!armed)
    mode == 2'b10 |=> par_out == '0);

  p_feedback_r5: assert property (@(posedge clk) disable iff (!armed)
    mode == 2'b01 |=> par_out[0] == ($past(fb_bit) ^ $past(par_in[0])));

  p_signature_r6: assert property (@(posedge clk) disable iff (!armed)
    mode == 2'b01 |=> par_out ==
      ({$past(par_out[WIDTH-2:0]), ^($past(par_out) & TAP_MASK)} ^ $past(par_in)));

  p_lock_r7: assert property (@(posedge clk) disable iff (!armed)
    (mode == 2'b01 && par_out == '0 && par_in == '0) |=> par_out == '0);
endmodule

bind logic_block_observer logic_block_observer_chk #(
  .WIDTH(WIDTH), .TAP_MASK(TAP_MASK)
) u_chk (
  .clk      (clk),
  .mode     (mode),
  .par_in   (par_in),
  .scan_in  (scan_in),
  .par_out  (par_out),
  .scan_out (scan_out),
  .fb_bit   (fb_bit)
);

// File: tb/logic_block_observer_test.sv
module logic_block_observer_test;
  localparam int          W        = 3;
  localparam logic [W-1:0] MASK    = 3'b101;
  localparam time         CLK_PER  = 10ns;
  localparam int          WD_LIMIT = 100000;

  logic         clk = 1'b0;
  logic [1:0]   mode = 2'b10;
  logic [W-1:0] par_in = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] par_out;
  logic         scan_out;

  logic_block_observer #(.WIDTH(W), .TAP_MASK(MASK)) uut (
    .clk      (clk),
    .mode     (mode),
    .par_in   (par_in),
    .scan_in  (scan_in),
    .par_out  (par_out),
    .scan_out (scan_out)
  );

  always #(CLK_PER/2) clk = ~clk;

  typedef struct {
    logic [W-1:0] q;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           checks = 0;
  int           errors = 0;
  logic [W-1:0] model = '0;
  bit           done = 1'b0;

  // Independent restatement of the four behaviours, bit by bit.
  function automatic logic [W-1:0] ref_step(input logic [1:0] m,
                                            input logic [W-1:0] cur,
                                            input logic [W-1:0] d,
                                            input logic si);
    logic [W-1:0] r;
    logic         par;
    par = 1'b0;
    for (int k = 0; k < W; k++) if (MASK[k]) par = par ^ cur[k];
    case (m)
      2'b10: r = '0;
      2'b11: r = d;
      2'b00: begin
        r[0] = si;
        for (int k = 1; k < W; k++) r[k] = cur[k-1];
      end
      default: begin
        r[0] = par ^ d[0];
        for (int k = 1; k < W; k++) r[k] = cur[k-1] ^ d[k];
      end
    endcase
    return r;
  endfunction

  task automatic push_cycle(input logic [1:0] m, input logic [W-1:0] d,
                            input logic si, input logic [W-1:0] exp_q,
                            input string tag);
    @(negedge clk);
    mode    = m;
    par_in  = d;
    scan_in = si;
    model   = exp_q;
    sb.push_back('{q: exp_q, tag: tag});
    @(posedge clk);
  endtask

  task automatic drive(input logic [1:0] m, input logic [W-1:0] d,
                       input logic si, input string tag);
    push_cycle(m, d, si, ref_step(m, model, d, si), tag);
  endtask

  // Monitor: compare each result one step after the edge that made it.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (par_out !== e.q) begin
        errors++;
        $display("FAIL %s par_out actual %b expected %b", e.tag, par_out, e.q);
      end
      checks++;
      if (scan_out !== e.q[W-1]) begin
        errors++;
        $display("FAIL R3 (%s) scan_out actual %b expected %b", e.tag, scan_out, e.q[W-1]);
      end
    end
  end

  initial begin
    logic [W-1:0] cyc [0:6];
    logic [W-1:0] vecs [0:5];
    logic [W-1:0] word;
    cyc[0] = 3'b110; cyc[1] = 3'b101; cyc[2] = 3'b010; cyc[3] = 3'b100;
    cyc[4] = 3'b001; cyc[5] = 3'b011; cyc[6] = 3'b111;
    vecs[0] = 3'b011; vecs[1] = 3'b101; vecs[2] = 3'b000;
    vecs[3] = 3'b110; vecs[4] = 3'b001; vecs[5] = 3'b111;

    // R4: reset state via clear code
    drive(2'b10, 3'b111, 1'b1, "R4 clear from power-up");
    // R1: parallel loads of several words
    drive(2'b11, 3'b111, 1'b0, "R1 load 111");
    // R5: pattern cycle from seed 111 against fixed table
    for (int k = 0; k < 7; k++) push_cycle(2'b01, '0, 1'b0, cyc[k], "R5 pattern step");
    drive(2'b11, 3'b010, 1'b1, "R1 load 010");
    drive(2'b11, 3'b101, 1'b0, "R1 load 101");
    drive(2'b10, 3'b000, 1'b1, "R4 clear nonzero");
    // R7: all-zero lock
    for (int k = 0; k < 3; k++) drive(2'b01, '0, 1'b1, "R7 zero lock");
    // R2/R8: scan a word in MSB first, then out
    word = 3'b110;
    for (int k = W - 1; k >= 0; k--) drive(2'b00, 3'b111, word[k], "R2 shift in");
    push_cycle(2'b11, 3'b110, 1'b0, word, "R8 word held after shift-in");
    for (int k = 0; k < W; k++) drive(2'b00, '0, 1'b0, "R8 shift out");
    // R6: signature over fixed responses from seed 111
    drive(2'b11, 3'b111, 1'b0, "R1 seed for signature");
    for (int k = 0; k < 6; k++) drive(2'b01, vecs[k], 1'b0, "R6 compaction step");
    push_cycle(2'b11, 3'b010, 1'b0, 3'b010, "R6 final signature 010 reloaded");
    drive(2'b00, '0, 1'b1, "R2 shift after signature");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < WD_LIMIT) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", n);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule